// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Front End

This block is the bus-facing half of a byte-addressed serial memory. It watches the clock and data lines of a two-wire bus with a fast system clock, cleans them with a synchronizer and a glitch filter, and recognises start and stop conditions. After each start it shifts in a control byte, checks it against a fixed device code and the board strap inputs, and pulls the data line low for the acknowledge slot when the byte selects it.

Once selected for a write, it takes two address bytes and any number of data bytes and acknowledges each one. Each completed byte is reported on a strobe for the neighbouring address pointer and write controller. Once selected for a read, it fetches bytes from the read data input and shifts them out MSB first. It keeps doing so while the master acknowledges, and lets go of the line at the first missing acknowledge. While the write controller reports a write cycle in progress, the block leaves control bytes unanswered, so the master can poll for completion. Data changes on the line are held back by a configurable number of clocks after each falling clock edge, so that a transmitted bit is never mistaken for a start or stop.

Top module: `serial_mem_target`

## Requirements
- R1: A falling data line while the clock is high (start) begins a new control byte at any point, discarding a partly received byte. A rising data line while the clock is high (stop) returns the block to idle. Both conditions release the data line on the next cycle. After reset the data line is released.
- R2: The control byte arrives MSB first. Bits 7:4 must equal 1010. Bit 3 is the block bit. Bits 2:1 are the chip select and must equal `strap_sel`. Bit 0 selects a read when 1. A matching byte is acknowledged (data line low through the ninth clock) and reported on `ctl_stb`, with the byte on `rx_byte_o`. Any other byte gets no acknowledge, and the block stays silent until the next start.
- R3: While `strap_fix` is low, no control byte is ever acknowledged.
- R4: While `busy_i` is high, no control byte is acknowledged.
- R5: After a write control byte, the block acknowledges the next three byte types and pulses one strobe for each, with the byte on `rx_byte_o`: the high address byte on `addr_hi_stb`, the low address byte on `addr_lo_stb`, and every further byte on `wr_data_stb`. At most one of the byte strobes is high in any cycle.
- R6: After a read control byte is acknowledged, the block samples `rd_data_i`, pulses `rd_adv_stb`, and transmits the byte MSB first. It releases the line for the master's acknowledge slot. A master acknowledge (low) starts the next byte the same way. A master non-acknowledge leaves the line released until the next start.
- R7: A write control byte with two address bytes, followed by a repeated start and a read control byte, returns the byte at that address. A read control byte straight after a start returns the byte at the pointer left by earlier transfers.
- R8: Every change of the data line drive other than a release at a start or stop comes at least `HOLD_CLKS` clocks after the clock line falls, and only while the filtered clock is low.
- R9: A pulse on either bus line shorter than `FILT_CLKS` system clocks has no effect on bit counting or condition detection.
- R10: `wr_go_stb` pulses once at a stop that ends a write command carrying at least one data byte. A write command that ends with no data byte, or that is cut by a repeated start, gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low (open-drain enable) |
| strap_sel | input | 2 | Board strap compared with control byte bits 2:1 |
| strap_fix | input | 1 | Fixed strap; must be high for any response |
| busy_i | input | 1 | Write cycle in progress; control bytes go unanswered |
| rd_data_i | input | 8 | Byte at the current address pointer |
| ctl_stb | output | 1 | Accepted control byte on rx_byte_o |
| addr_hi_stb | output | 1 | High address byte on rx_byte_o |
| addr_lo_stb | output | 1 | Low address byte on rx_byte_o |
| wr_data_stb | output | 1 | Write data byte on rx_byte_o |
| rd_adv_stb | output | 1 | rd_data_i taken for transmit; pointer may advance |
| wr_go_stb | output | 1 | Stop after a write with data; start the write cycle |
| rx_byte_o | output | 8 | Last byte received |

## Verification
The hardest case to reach from the ports is a start arriving in the middle of a byte. The bench sends a write control byte and a high address byte, clocks three bits of the low address byte, and then issues a repeated start followed by a read. The read must return the byte at the old pointer, which shows that the partial byte was discarded. The other hard case is a clock glitch shorter than the filter window. The bench places a short high pulse on the clock line during the low phase ahead of a control byte's first bit. Any extra counted bit would misalign the code and lose the acknowledge, so the acknowledge proves the glitch was ignored.

// File: rtl/smt_pkg.sv
package smt_pkg;
   localparam logic [3:0] DEV_CODE   = 4'b1010;
   localparam int         BYTE_BITS  = 8;
   localparam int         SEL_W      = 2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CTRL,
      ST_AHI,
      ST_ALO,
      ST_WDAT,
      ST_TX,
      ST_SKIP
   } seq_st_t;
endpackage

// File: rtl/smt_line_filter.sv
module smt_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CLKS   = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   localparam int CW = $clog2(FILT_CLKS + 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic [CW-1:0]          run_q;
   logic                   sync_last;

   assign sync_last = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         run_q  <= '0;
         line_o <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
         if (sync_last != line_o) begin
            if (run_q == CW'(FILT_CLKS - 1)) begin
               line_o <= sync_last;
               run_q  <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end else begin
            run_q <= '0;
         end
      end
   end

   // R9: the filtered line only takes a value the synchronised line held
   a_r9_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(line_o) |-> $past(sync_last) == line_o)
      else $error("filtered line took a value the input did not hold");
endmodule

// File: rtl/smt_bus_events.sv
module smt_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   assign scl_rise = scl_f & ~scl_q;
   assign scl_fall = ~scl_f & scl_q;
   assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
   assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;

   // R1: start and stop never fire together
   a_r1_cond_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_ev && stop_ev))
      else $error("start and stop seen in one cycle");
endmodule

// File: rtl/smt_drive_hold.sv
module smt_drive_hold #(
   parameter int HOLD_CLKS = 30
) (
   input  logic clk,
   input  logic rst_n,
   input  logic want_low,
   input  logic scl_fall,
   input  logic scl_hi,
   input  logic rel_now,
   output logic sda_oe
);
   localparam int CW = $clog2(HOLD_CLKS + 1);

   logic [CW-1:0] wait_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_q <= '0;
         sda_oe <= 1'b0;
      end else begin
         if (scl_fall)
            wait_q <= CW'(HOLD_CLKS);
         else if (wait_q != '0)
            wait_q <= wait_q - 1'b1;

         if (rel_now)
            sda_oe <= 1'b0;
         else if (wait_q == '0 && !scl_hi && !scl_fall)
            sda_oe <= want_low;
      end
   end

   // R1: a start or stop releases the line on the next cycle
   a_r1_release_on_cond: assert property (@(posedge clk) disable iff (!rst_n)
      rel_now |=> !sda_oe)
      else $error("line still driven after start/stop");
   // R8: the drive does not move right after a clock fall
   a_r8_quiet_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_fall && !rel_now) |=> $stable(sda_oe))
      else $error("drive changed right after clock fall");
   // R8: the drive is only taken while the clock is low
   a_r8_take_low_only: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !$past(scl_hi))
      else $error("drive asserted with clock high");
endmodule

// File: rtl/smt_byte_seq.sv
module smt_byte_seq
   import smt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_ev,
   input  logic             stop_ev,
   input  logic             sda_f,
   input  logic [SEL_W-1:0] strap_sel,
   input  logic             strap_fix,
   input  logic             busy_i,
   input  logic [7:0]       rd_data_i,
   output logic             want_low,
   output logic             ctl_stb,
   output logic             addr_hi_stb,
   output logic             addr_lo_stb,
   output logic             wr_data_stb,
   output logic             rd_adv_stb,
   output logic             wr_go_stb,
   output logic [7:0]       rx_byte_o
);
   seq_st_t    st_q;
   logic [3:0] bitn_q;
   logic [7:0] rx_sh_q;
   logic [6:0] tx_sh_q;
   logic       rd_cmd_q, m_ack_q, wrote_q;
   logic       ctl_match;

   assign ctl_match = (rx_sh_q[7:4] == DEV_CODE) && (rx_sh_q[2:1] == strap_sel)
                      && strap_fix && !busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;   bitn_q <= '0;      rx_sh_q <= '0;   tx_sh_q <= '0;
         rd_cmd_q <= 1'b0;  m_ack_q <= 1'b0;   wrote_q <= 1'b0; want_low <= 1'b0;
         ctl_stb <= 1'b0;   addr_hi_stb <= 1'b0; addr_lo_stb <= 1'b0;
         wr_data_stb <= 1'b0; rd_adv_stb <= 1'b0; wr_go_stb <= 1'b0; rx_byte_o <= '0;
      end else begin
         ctl_stb <= 1'b0; addr_hi_stb <= 1'b0; addr_lo_stb <= 1'b0;
         wr_data_stb <= 1'b0; rd_adv_stb <= 1'b0; wr_go_stb <= 1'b0;
         if (start_ev) begin
            st_q <= ST_CTRL;  bitn_q <= '0;  want_low <= 1'b0;  wrote_q <= 1'b0;
         end else if (stop_ev) begin
            st_q <= ST_IDLE;  bitn_q <= '0;  want_low <= 1'b0;
            wr_go_stb <= wrote_q;  wrote_q <= 1'b0;
         end else if (st_q != ST_IDLE && st_q != ST_SKIP) begin
            if (scl_rise) begin
               bitn_q <= bitn_q + 4'd1;
               if (bitn_q < 4'd8) rx_sh_q <= {rx_sh_q[6:0], sda_f};
               else               m_ack_q <= !sda_f;
            end else if (scl_fall) begin
               if (bitn_q == 4'd8) begin
                  if (st_q == ST_TX) begin
                     want_low <= 1'b0;
                  end else begin
                     rx_byte_o <= rx_sh_q;
                     unique case (st_q)
                        ST_CTRL: if (ctl_match) begin
                                    want_low <= 1'b1; ctl_stb <= 1'b1; rd_cmd_q <= rx_sh_q[0];
                                 end else begin
                                    st_q <= ST_SKIP;
                                 end
                        ST_AHI:  begin want_low <= 1'b1; addr_hi_stb <= 1'b1; end
                        ST_ALO:  begin want_low <= 1'b1; addr_lo_stb <= 1'b1; end
                        default: begin want_low <= 1'b1; wr_data_stb <= 1'b1; wrote_q <= 1'b1; end
                     endcase
                  end
               end else if (bitn_q == 4'd9) begin
                  bitn_q <= '0;
                  if ((st_q == ST_CTRL && rd_cmd_q) || (st_q == ST_TX && m_ack_q)) begin
                     st_q <= ST_TX;  tx_sh_q <= rd_data_i[6:0];
                     want_low <= !rd_data_i[7];  rd_adv_stb <= 1'b1;
                  end else begin
                     want_low <= 1'b0;
                     unique case (st_q)
                        ST_CTRL: st_q <= ST_AHI;
                        ST_AHI:  st_q <= ST_ALO;
                        ST_ALO:  st_q <= ST_WDAT;
                        ST_TX:   st_q <= ST_SKIP;
                        default: st_q <= ST_WDAT;
                     endcase
                  end
               end else if (st_q == ST_TX && bitn_q != 4'd0) begin
                  tx_sh_q  <= {tx_sh_q[5:0], 1'b0};
                  want_low <= !tx_sh_q[6];
               end
            end
         end
      end
   end

   // R4: no control byte is accepted while a write cycle runs
   a_r4_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_stb |-> !$past(busy_i))
      else $error("control byte accepted while busy");
   // R3: no control byte is accepted without the fixed strap
   a_r3_fixed_strap: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_stb |-> $past(strap_fix))
      else $error("control byte accepted with fixed strap low");
   // R2: an accepted control byte carries the code and strap select
   a_r2_ctl_fields: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_stb |-> (rx_byte_o[7:4] == DEV_CODE && rx_byte_o[2:1] == $past(strap_sel)))
      else $error("control byte accepted with wrong fields");
   // R5: byte strobes are mutually exclusive
   a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctl_stb, addr_hi_stb, addr_lo_stb, wr_data_stb, rd_adv_stb}))
      else $error("several byte strobes at once");
   // R1: a start or stop withdraws the drive request
   a_r1_cond_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ev || stop_ev) |=> !want_low)
      else $error("drive request kept over start/stop");
endmodule

// File: rtl/serial_mem_target.sv
module serial_mem_target
   import smt_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CLKS   = 6,
   parameter int HOLD_CLKS   = 30
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   input  logic [SEL_W-1:0] strap_sel,
   input  logic             strap_fix,
   input  logic             busy_i,
   input  logic [7:0]       rd_data_i,
   output logic             ctl_stb,
   output logic             addr_hi_stb,
   output logic             addr_lo_stb,
   output logic             wr_data_stb,
   output logic             rd_adv_stb,
   output logic             wr_go_stb,
   output logic [7:0]       rx_byte_o
);
   localparam int N_LINES = 2;
   localparam int L_SCL   = 0;
   localparam int L_SDA   = 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_CLKS < 1) begin : g_bad_filt
      $error("FILT_CLKS must be at least 1");
   end
   if (HOLD_CLKS < 1) begin : g_bad_hold
      $error("HOLD_CLKS must be at least 1");
   end

   logic [N_LINES-1:0] raw, filt;
   logic scl_rise, scl_fall, start_ev, stop_ev, want_low;

   assign raw[L_SCL] = scl_i;
   assign raw[L_SDA] = sda_i;

   for (genvar g = 0; g < N_LINES; g++) begin : g_line
      smt_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CLKS(FILT_CLKS)) u_filt (
         .clk(clk), .rst_n(rst_n), .line_i(raw[g]), .line_o(filt[g]));
   end

   smt_bus_events u_ev (
      .clk(clk), .rst_n(rst_n), .scl_f(filt[L_SCL]), .sda_f(filt[L_SDA]),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev));

   smt_byte_seq u_seq (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev), .sda_f(filt[L_SDA]),
      .strap_sel(strap_sel), .strap_fix(strap_fix), .busy_i(busy_i), .rd_data_i(rd_data_i),
      .want_low(want_low), .ctl_stb(ctl_stb), .addr_hi_stb(addr_hi_stb),
      .addr_lo_stb(addr_lo_stb), .wr_data_stb(wr_data_stb), .rd_adv_stb(rd_adv_stb),
      .wr_go_stb(wr_go_stb), .rx_byte_o(rx_byte_o));

   smt_drive_hold #(.HOLD_CLKS(HOLD_CLKS)) u_hold (
      .clk(clk), .rst_n(rst_n), .want_low(want_low), .scl_fall(scl_fall),
      .scl_hi(filt[L_SCL]), .rel_now(start_ev | stop_ev), .sda_oe(sda_oe));

   // R10: the write-cycle request only comes with a stop
   a_r10_go_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
      wr_go_stb |-> $past(stop_ev))
      else $error("write request without stop");
endmodule

// File: tb/serial_mem_target_tb_top.sv
module serial_mem_target_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int Q          = 25;
   localparam int FILT       = 6;
   localparam int HOLD       = 30;
   localparam int GLITCH     = FILT - 2;
   localparam int WATCHDOG   = 190000;

   // vector: [12:5] control byte, [4:3] strap_sel, [2] strap_fix, [1] busy, [0] expect ack
   localparam logic [12:0] VEC [8] = '{
      {8'hA2, 2'b01, 1'b1, 1'b0, 1'b1},
      {8'hA4, 2'b01, 1'b1, 1'b0, 1'b0},
      {8'hB2, 2'b01, 1'b1, 1'b0, 1'b0},
      {8'hAA, 2'b01, 1'b1, 1'b0, 1'b1},
      {8'hA2, 2'b01, 1'b0, 1'b0, 1'b0},
      {8'hA2, 2'b01, 1'b1, 1'b1, 1'b0},
      {8'hA3, 2'b01, 1'b1, 1'b0, 1'b1},
      {8'hA6, 2'b11, 1'b1, 1'b0, 1'b1}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic [1:0] strap_sel = 2'b01;
   logic strap_fix = 1'b1, busy = 1'b0;
   logic sda_oe, ctl_stb, addr_hi_stb, addr_lo_stb, wr_data_stb, rd_adv_stb, wr_go_stb;
   logic [7:0] rx_byte, rd_data;
   logic sda_line;

   logic [7:0]  mem [512];
   logic [15:0] ptr;
   logic [7:0]  hi_pend, last_ctl;
   int wr_go_cnt, since_fall, min_gap;
   logic scl_prev, oe_prev;
   int checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign sda_line = sda_m & ~sda_oe;
   assign rd_data  = mem[ptr[8:0]];

   serial_mem_target #(.FILT_CLKS(FILT), .HOLD_CLKS(HOLD)) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
      .strap_sel(strap_sel), .strap_fix(strap_fix), .busy_i(busy), .rd_data_i(rd_data),
      .ctl_stb(ctl_stb), .addr_hi_stb(addr_hi_stb), .addr_lo_stb(addr_lo_stb),
      .wr_data_stb(wr_data_stb), .rd_adv_stb(rd_adv_stb), .wr_go_stb(wr_go_stb),
      .rx_byte_o(rx_byte));

   // neighbour model: address pointer and memory, plus line timing monitor
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 512; i++) mem[i] <= 8'(i) ^ 8'h3C;
         ptr <= '0; hi_pend <= '0; last_ctl <= '0; wr_go_cnt <= 0;
         since_fall <= 0; min_gap <= 1000000; scl_prev <= 1'b1; oe_prev <= 1'b0;
      end else begin
         if (addr_hi_stb) hi_pend <= rx_byte;
         if (addr_lo_stb) ptr <= {hi_pend, rx_byte};
         if (wr_data_stb) begin mem[ptr[8:0]] <= rx_byte; ptr <= ptr + 16'd1; end
         if (rd_adv_stb)  ptr <= ptr + 16'd1;
         if (ctl_stb)     last_ctl <= rx_byte;
         if (wr_go_stb)   wr_go_cnt <= wr_go_cnt + 1;
         scl_prev <= scl_m;
         oe_prev  <= sda_oe;
         if (scl_prev && !scl_m) since_fall <= 1;
         else                    since_fall <= since_fall + 1;
         if (oe_prev != sda_oe && since_fall < min_gap) min_gap <= since_fall;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic nclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_xfer(input logic b, input logic glitch, output logic r);
      nclk(2*Q);
      if (glitch) begin scl_m = 1'b1; nclk(GLITCH); scl_m = 1'b0; end
      sda_m = b;
      nclk(Q); scl_m = 1'b1;
      nclk(Q); r = sda_line;
      nclk(Q); scl_m = 1'b0;
   endtask

   task automatic bus_start();
      if (!scl_m) begin
         nclk(2*Q); sda_m = 1'b1; nclk(Q); scl_m = 1'b1; nclk(Q);
      end
      sda_m = 1'b0; nclk(Q); scl_m = 1'b0;
   endtask

   task automatic bus_stop();
      nclk(2*Q); sda_m = 1'b0; nclk(Q); scl_m = 1'b1; nclk(Q); sda_m = 1'b1; nclk(2*Q);
   endtask

   task automatic send_byte(input logic [7:0] b, input logic glitch, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) bit_xfer(b[i], glitch && (i == 7), r);
      bit_xfer(1'b1, 1'b0, r);
      ack = !r;
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] d);
      logic r;
      d = '0;
      for (int i = 0; i < 8; i++) begin bit_xfer(1'b1, 1'b0, r); d = {d[6:0], r}; end
      bit_xfer(!mack, 1'b0, r);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      logic ack;
      logic [7:0] d;
      nclk(5); rst_n = 1'b1; nclk(10);
      chk("R1 reset releases line", int'(sda_oe), 0);
      chk("R5 reset strobes idle",
          int'({ctl_stb, addr_hi_stb, addr_lo_stb, wr_data_stb, rd_adv_stb, wr_go_stb}), 0);

      // vector table of control bytes: R2 R3 R4 R6
      for (int i = 0; i < 8; i++) begin
         logic [12:0] v;
         v = VEC[i];
         strap_sel = v[4:3]; strap_fix = v[2]; busy = v[1];
         nclk(4*Q);
         bus_start();
         send_byte(v[12:5], 1'b0, ack);
         chk($sformatf("R2/R3/R4 vector %0d ack", i), int'(ack), int'(v[0]));
         if (v[0]) chk($sformatf("R2 vector %0d control byte", i), int'(last_ctl), int'(v[12:5]));
         if (v[0] && v[5]) recv_byte(1'b0, d);
         busy = 1'b0;
         bus_stop();
      end
      strap_sel = 2'b01; strap_fix = 1'b1;
      chk("R10 no write request without data", wr_go_cnt, 0);

      // R5 R10 write of two bytes at 0x0110
      bus_start();
      send_byte(8'hA2, 1'b0, ack); chk("R5 control ack", int'(ack), 1);
      send_byte(8'h01, 1'b0, ack); chk("R5 high address ack", int'(ack), 1);
      send_byte(8'h10, 1'b0, ack); chk("R5 low address ack", int'(ack), 1);
      send_byte(8'h5A, 1'b0, ack); chk("R5 data 0 ack", int'(ack), 1);
      send_byte(8'hC3, 1'b0, ack); chk("R5 data 1 ack", int'(ack), 1);
      bus_stop();
      nclk(4);
      chk("R10 one write request", wr_go_cnt, 1);
      chk("R5 data 0 stored", int'(mem[9'h110]), 8'h5A);
      chk("R5 data 1 stored", int'(mem[9'h111]), 8'hC3);

      // R7 random read, R6 sequential with master ack then nack
      bus_start();
      send_byte(8'hA2, 1'b0, ack);
      send_byte(8'h01, 1'b0, ack);
      send_byte(8'h10, 1'b0, ack);
      bus_start();
      send_byte(8'hA3, 1'b0, ack); chk("R7 read control ack", int'(ack), 1);
      recv_byte(1'b1, d); chk("R7 random read byte", int'(d), 8'h5A);
      recv_byte(1'b0, d); chk("R6 sequential next byte", int'(d), 8'hC3);
      nclk(2*Q);
      chk("R6 line released after nack", int'(sda_oe), 0);
      bus_stop();
      chk("R10 read gives no write request", wr_go_cnt, 1);

      // R7 current address read
      bus_start();
      send_byte(8'hA3, 1'b0, ack);
      recv_byte(1'b0, d); chk("R7 current address byte", int'(d), 8'h2E);
      bus_stop();

      // R1 start in the middle of a byte discards it
      bus_start();
      send_byte(8'hA2, 1'b0, ack);
      send_byte(8'h00, 1'b0, ack);
      for (int i = 0; i < 3; i++) begin logic r; bit_xfer(1'b0, 1'b0, r); end
      bus_start();
      send_byte(8'hA3, 1'b0, ack); chk("R1 control ack after abort", int'(ack), 1);
      recv_byte(1'b0, d); chk("R1 pointer kept after abort", int'(d), 8'h2F);
      bus_stop();

      // R9 short clock pulse before first control bit
      bus_start();
      send_byte(8'hA2, 1'b1, ack); chk("R9 clock glitch ignored", int'(ack), 1);
      bus_stop();
      chk("R10 address-only write gives no request", wr_go_cnt, 1);

      // R8 drive changes held after clock fall
      chk("R8 hold after clock fall", int'(min_gap >= HOLD), 1);

      summary();
      $finish;
   end
endmodule